// File: doc/BRIEF.md
# Two-Register Microcoded Processor Core

This block is a very small processor core. It holds two 8-bit data registers, X and T, a carry flag and a sign flag. It reads opcodes and immediate bytes from a read-only program port, addressed by its program counter. Each instruction runs as a short fixed sequence of micro-steps. The first step fetches the opcode. An operand step follows when the instruction carries an immediate byte. Then the instruction executes. The exchange of X and T uses three execute steps, each applying an exclusive-OR between the two registers, so no third register is needed.

The program port is combinational: `imem_data` must present the byte at `imem_addr` in the same cycle. Execution begins at address 0 when the active-low reset is released. Jumps take an 8-bit absolute target, so they can only land in the lowest 256 bytes of program space. Fetching opcode FF stops the core, and it stays stopped until the next reset. The current opcode and the value of X are brought out on debug ports for observation.

Top module: `mini_core`

## Requirements
- R1: While `rst_n` is low, and at the release of reset, `imem_addr` is 0, `halted` is 0 and `dbg_x` is 0. The carry and sign flags are also cleared. The first fetch after release reads address 0.
- R2: Opcode 01 (load) takes the next byte as an immediate, writes it to X, and sets the sign flag to bit 7 of that byte.
- R3: Opcode 02 (exchange) swaps the contents of X and T. It does this with three steps, X^=T, then T^=X, then X^=T.
- R4: Opcode 04 (add) writes the low 8 bits of X+T+carry into X. It sets carry to the carry out of bit 7, and sets the sign flag to bit 7 of the sum.
- R5: Opcode 03 clears the carry flag, so a following add adds no carry-in.
- R6: Opcode 05 takes the next byte as a target. When the sign flag is 1 it jumps there, with the target zero-extended to the full address width, even when it executes above address 255. Otherwise execution falls through past the target byte.
- R7: Opcode 06 takes the next byte as a target. It jumps there, zero-extended, when the sign flag is 0, and falls through otherwise.
- R8: Fetching opcode FF raises `halted`. From then until reset, `imem_addr` and `dbg_x` hold their values, whatever bytes follow in program memory.
- R9: Every opcode other than 00–06 and FF acts like opcode 00. It has no operand, it leaves X, T and carry unchanged, and execution moves to the next byte.
- R10: Instruction length in clock cycles is 2 for opcodes 00, 03, 04 and undefined opcodes, 3 for 01, 05 and 06, and 4 for 02. The fetch of FF sets `halted` one cycle after that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | ADDR_W | Program memory address (program counter) |
| imem_data | input | 8 | Program byte at `imem_addr`, same cycle |
| halted | output | 1 | High once opcode FF has been fetched |
| dbg_opcode | output | 8 | Opcode of the instruction in progress |
| dbg_x | output | 8 | Current contents of X |

## Verification
The bench targets these corner cases:
- Exchange: it loads distinct values into X and T, then observes both after a double exchange. A faulty XOR step would leave one register as the XOR of the two.
- Add with carry: it chains adds that overflow, so a carry-in that is dropped or not cleared shows up as an off-by-one in X.
- Jump above 255: it jumps from above address 255. A core that kept the upper counter bits would land in the wrong page and never reach the marker code.
- Stopping: it places instructions after FF. A core that kept fetching would change X.
- Undefined opcodes: it checks that an undefined opcode skips no byte and makes no change.
- Timing: cycle counts to halt expose a wrong micro-step count.
- Full program: a Fibonacci loop ties all of this together and must stop with X at 144.

// File: rtl/mini_core.sv
module mini_core #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [7:0]        imem_data,
  output logic              halted,
  output logic [7:0]        dbg_opcode,
  output logic [7:0]        dbg_x
);

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h01;
  localparam logic [7:0] OP_SWAP = 8'h02;
  localparam logic [7:0] OP_CLC  = 8'h03;
  localparam logic [7:0] OP_ADD  = 8'h04;
  localparam logic [7:0] OP_JMI  = 8'h05;
  localparam logic [7:0] OP_JPL  = 8'h06;
  localparam logic [7:0] OP_HALT = 8'hFF;
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND, ST_EXEC, ST_SWAP2, ST_SWAP3, ST_HALT
  } step_t;

  step_t             step;
  logic [ADDR_W-1:0] pc;
  logic [7:0]        op, opnd, x, t;
  logic              c, n;

  logic [8:0] sum;
  logic       has_opnd, take, op_known;

  assign sum      = {1'b0, x} + {1'b0, t} + {8'd0, c};
  assign has_opnd = (imem_data == OP_LDX) || (imem_data == OP_JMI) || (imem_data == OP_JPL);
  assign take     = ((op == OP_JMI) && n) || ((op == OP_JPL) && !n);
  assign op_known = (op <= OP_JPL);

  assign imem_addr  = pc;
  assign halted     = (step == ST_HALT);
  assign dbg_opcode = op;
  assign dbg_x      = x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_FETCH;
      pc   <= '0;
      op   <= OP_NOP;
      opnd <= 8'd0;
      x    <= 8'd0;
      t    <= 8'd0;
      c    <= 1'b0;
      n    <= 1'b0;
    end else begin
      case (step)
        ST_FETCH: begin
          op <= imem_data;
          if (imem_data == OP_HALT) begin
            step <= ST_HALT;
          end else begin
            pc   <= pc + PC_ONE;
            step <= has_opnd ? ST_OPND : ST_EXEC;
          end
        end
        ST_OPND: begin
          opnd <= imem_data;
          pc   <= pc + PC_ONE;
          step <= ST_EXEC;
        end
        ST_EXEC: begin
          step <= ST_FETCH;
          case (op)
            OP_NOP: ;
            OP_LDX: begin
              x <= opnd;
              n <= opnd[7];
            end
            OP_SWAP: begin
              x    <= x ^ t;
              step <= ST_SWAP2;
            end
            OP_CLC: c <= 1'b0;
            OP_ADD: begin
              x <= sum[7:0];
              c <= sum[8];
              n <= sum[7];
            end
            OP_JMI, OP_JPL: if (take) pc <= ADDR_W'(opnd);
            default: ;
          endcase
        end
        ST_SWAP2: begin
          t    <= t ^ x;
          step <= ST_SWAP3;
        end
        ST_SWAP3: begin
          x    <= x ^ t;
          step <= ST_FETCH;
        end
        default: step <= ST_HALT;
      endcase
    end
  end

  p_fetch_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH && imem_data != OP_HALT) |=> (imem_addr == $past(imem_addr) + PC_ONE));

  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && op == OP_SWAP) |=> ##2 (x == $past(t, 3) && t == $past(x, 3)));

  p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && op == OP_ADD)
      |=> ({c, x} == {1'b0, $past(x)} + {1'b0, $past(t)} + {8'd0, $past(c)}));

  p_clc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && op == OP_CLC) |=> !c);

  p_jmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && op == OP_JMI && n) |=> (imem_addr == ADDR_W'($past(opnd))));

  p_jpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && op == OP_JPL && !n) |=> (imem_addr == ADDR_W'($past(opnd))));

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(imem_addr) && $stable(dbg_x)));

  p_undef_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && !op_known) |=> ($stable(x) && $stable(t) && $stable(c) && step == ST_FETCH));

endmodule

// File: tb/mini_core_bench.sv
module mini_core_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [7:0]    imem_data;
  logic          halted;
  logic [7:0]    dbg_opcode, dbg_x;
  logic [7:0]    prog [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;
  int total_cyc = 0;

  always #5 clk = ~clk;
  assign imem_data = prog[imem_addr];

  mini_core #(.ADDR_W(AW)) u_mini_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .halted(halted), .dbg_opcode(dbg_opcode), .dbg_x(dbg_x)
  );

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", total_cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < (1 << AW); i++) prog[i] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_halt(input int limit, output int cyc);
    cyc = 0;
    while (!halted && cyc < limit) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h5A; prog[2] = 8'hFF;
    do_reset();
    run_halt(20, cyc);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 addr in reset", imem_addr, 0);
    chk("R1 halted in reset", halted, 0);
    chk("R1 x in reset", dbg_x, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first fetch addr", imem_addr, 0);
    run_halt(20, cyc);
    chk("R1 rerun x", dbg_x, 8'h5A);
  endtask

  task automatic t_load_jmi();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h85; prog[2] = 8'h05; prog[3] = 8'h08;
    prog[4] = 8'h01; prog[5] = 8'h11; prog[6] = 8'hFF;
    prog[8] = 8'h01; prog[9] = 8'h22; prog[10] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R6 jmi taken x", dbg_x, 8'h22);
    chk("R10 cycles load+jmi+load+halt", cyc, 10);
    chk("R2 halt addr", imem_addr, 10);
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h05; prog[2] = 8'h05; prog[3] = 8'h08;
    prog[4] = 8'h01; prog[5] = 8'h33; prog[6] = 8'hFF;
    prog[8] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R6 jmi not taken x", dbg_x, 8'h33);
  endtask

  task automatic t_jpl();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h05; prog[2] = 8'h06; prog[3] = 8'h08;
    prog[4] = 8'hFF; prog[8] = 8'h01; prog[9] = 8'h44; prog[10] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R7 jpl taken x", dbg_x, 8'h44);
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h80; prog[2] = 8'h06; prog[3] = 8'h08;
    prog[4] = 8'h01; prog[5] = 8'h55; prog[6] = 8'hFF; prog[8] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R7 jpl not taken x", dbg_x, 8'h55);
  endtask

  task automatic t_swap();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h3C; prog[2] = 8'h02;
    prog[3] = 8'h01; prog[4] = 8'hA5; prog[5] = 8'h02; prog[6] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R3 swap x", dbg_x, 8'h3C);
    chk("R10 cycles with swap", cyc, 15);
    prog[6] = 8'h02; prog[7] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R3 swap back t", dbg_x, 8'hA5);
  endtask

  task automatic t_add();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'hF0; prog[2] = 8'h02; prog[3] = 8'h01; prog[4] = 8'h20;
    prog[5] = 8'h03; prog[6] = 8'h04; prog[7] = 8'h04; prog[8] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R4 add with carry-in", dbg_x, 8'h01);
    prog[7] = 8'h03; prog[8] = 8'h04; prog[9] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R5 clc then add", dbg_x, 8'h00);
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h01; prog[2] = 8'h02; prog[3] = 8'h01; prog[4] = 8'h7F;
    prog[5] = 8'h03; prog[6] = 8'h04; prog[7] = 8'h05; prog[8] = 8'h30; prog[9] = 8'hFF;
    prog[8'h30] = 8'h01; prog[8'h31] = 8'h66; prog[8'h32] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R4 add sets sign", dbg_x, 8'h66);
  endtask

  task automatic t_undef();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h12; prog[2] = 8'h07; prog[3] = 8'h80; prog[4] = 8'hFF;
    do_reset();
    run_halt(100, cyc);
    chk("R9 undefined keeps x", dbg_x, 8'h12);
    chk("R9 undefined no operand addr", imem_addr, 4);
    chk("R10 cycles undefined", cyc, 8);
  endtask

  task automatic t_halt();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h12; prog[2] = 8'hFF; prog[3] = 8'h01; prog[4] = 8'h99;
    do_reset();
    run_halt(100, cyc);
    chk("R8 halted", halted, 1);
    chk("R10 cycles to halt", cyc, 4);
    repeat (20) @(negedge clk);
    chk("R8 still halted", halted, 1);
    chk("R8 addr held", imem_addr, 2);
    chk("R8 x held", dbg_x, 8'h12);
  endtask

  task automatic t_high_jump();
    int cyc;
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h80;
    prog[8'h20] = 8'h05; prog[8'h21] = 8'h25;
    prog[8'h22] = 8'h01; prog[8'h23] = 8'h3C; prog[8'h24] = 8'hFF;
    prog[10'h100] = 8'h01; prog[10'h101] = 8'h01;
    prog[10'h102] = 8'h06; prog[10'h103] = 8'h20;
    prog[10'h104] = 8'h01; prog[10'h105] = 8'h99; prog[10'h106] = 8'hFF;
    do_reset();
    run_halt(3000, cyc);
    chk("R6 zero-extended target x", dbg_x, 8'h3C);
    chk("R7 zero-extended target addr", imem_addr, 10'h024);
  endtask

  task automatic t_fib();
    int cyc;
    clear_prog();
    prog[0] = 8'h00; prog[1] = 8'h01; prog[2] = 8'h01; prog[3] = 8'h02;
    prog[4] = 8'h01; prog[5] = 8'h00; prog[6] = 8'h03; prog[7] = 8'h04;
    prog[8] = 8'h05; prog[9] = 8'h0D; prog[10] = 8'h02; prog[11] = 8'h06;
    prog[12] = 8'h06; prog[13] = 8'hFF;
    do_reset();
    run_halt(2000, cyc);
    chk("R4 fib result", dbg_x, 144);
    chk("R8 fib halted", halted, 1);
    do_reset();
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset addr", imem_addr, 0);
    chk("R1 mid-run reset x", dbg_x, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load_jmi();
    t_jpl();
    t_swap();
    t_add();
    t_undef();
    t_halt();
    t_high_jump();
    t_fib();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule